// File: doc/BRIEF.md
# Load-Banded PID Compensator with Integrator Bank

This block is the digital compensator of a buck regulator. It turns a signed output-error sample into a 13-bit duty command. Its one unusual feature is the integral path. There is no single integrator. Instead, a bank of integrators is kept, one for each band of load current. The top bits of a load-current code pick the band. Only that band's integrator accumulates error and feeds the output. Every other integrator keeps the value it last held.

When the regulator moves between discontinuous and continuous conduction, the steady-state duty can differ a lot from one band to the next. Each band's integrator resumes from its own stored value, so none of them has to slew across that gap. The feedback sum of proportional, integral and derivative terms is added to a feedforward term: a signed high-pass load-current sample times a programmable gain. The total is clamped to the modulator's range.

A sample strobe marks each compensator update. In the intended system the strobe arrives once every four fast clocks. Between strobes, all state and the output hold.

Top module: `pid_band_comp`

## Requirements
- R1: After reset, `dutyOut` is 0, every integrator holds 0 and the stored previous error is 0.
- R2: On a strobe, the band is `loadCode[7:5]`, read as an unsigned value 0..7. Exactly one integrator is selected.
- R3: On a strobe, integrators outside the selected band keep their value. When a band is selected again, it resumes from the value it last held.
- R4: On a strobe, the selected integrator becomes its value plus KI·err (KI = 4), saturated to the range −16000..+16000. This saturated value is the integral term of that same update.
- R5: The proportional term is KP·err (KP = 8), where `errIn` is a 10-bit two's-complement value.
- R6: The derivative term is KD·(err − previous err) (KD = 2). The previous error is replaced on every strobe, whatever the band.
- R7: The feedforward term is (ffIn·ffGain) arithmetically shifted right by 4. `ffIn` is an 8-bit two's-complement value and `ffGain` is an 8-bit unsigned value.
- R8: The duty command is the sum of the P, I, D and feedforward terms, clamped to 0..8191.
- R9: `dutyOut` changes only on the clock edge where `sampleStb` is high. It is valid from that edge on. Inputs presented without a strobe have no effect.
- R10: A synchronous reset that is asserted during operation clears all integrators, the previous error and the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleStb | input | 1 | Update strobe, one clock wide |
| errIn | input | 10 | Signed error sample |
| loadCode | input | 8 | Load-current level code |
| ffIn | input | 8 | Signed high-pass load-current sample |
| ffGain | input | 8 | Unsigned feedforward gain |
| dutyOut | output | 13 | Clamped duty command |

## Verification
The bench uses the default parameters: KP=8, KI=4, KD=2, a 4-bit feedforward shift, a 16-bit integrator limited to ±16000, and eight bands. With these values, a full-scale error of 511 drives an integrator into its limit within eight strobes. Both output clamps are also easy to reach. So the bench can run saturation, resume-after-band-change and clamp cases as directed sequences, alongside several hundred random strobes spread over all bands.

// File: rtl/pid_band_pkg.sv
package pid_band_pkg;
  localparam int PID_BAND_BITS = 3;
  localparam int PID_NUM_BANDS = 1 << PID_BAND_BITS;

  typedef struct packed {
    logic                     sample;
    logic [PID_BAND_BITS-1:0] bandIdx;
    logic [PID_NUM_BANDS-1:0] bandHot;
  } pid_ctl_t;
endpackage

// File: rtl/pid_band_ctl.sv
module pid_band_ctl
  import pid_band_pkg::*;
#(
  parameter int LOAD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleStb,
  input  logic [LOAD_W-1:0] loadCode,
  output pid_ctl_t          ctl
);
  always_comb begin
    ctl.sample  = sampleStb;
    ctl.bandIdx = loadCode[LOAD_W-1 -: PID_BAND_BITS];
    ctl.bandHot = '0;
    ctl.bandHot[ctl.bandIdx] = 1'b1;
  end

  // R2: a strobe always carries exactly one selected band
  assert_one_band_R2: assert property (@(posedge clk) disable iff (rst)
    ctl.sample |-> ($countones(ctl.bandHot) == 1));
endmodule

// File: rtl/pid_band_dp.sv
module pid_band_dp
  import pid_band_pkg::*;
#(
  parameter int ERR_W    = 10,
  parameter int FF_W     = 8,
  parameter int GAIN_W   = 8,
  parameter int DUTY_W   = 13,
  parameter int INT_W    = 16,
  parameter int INT_LIM  = 16000,
  parameter int KP       = 8,
  parameter int KI       = 4,
  parameter int KD       = 2,
  parameter int FF_SHIFT = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  pid_ctl_t                 ctl,
  input  logic signed [ERR_W-1:0]  errIn,
  input  logic signed [FF_W-1:0]   ffIn,
  input  logic [GAIN_W-1:0]        ffGain,
  output logic [DUTY_W-1:0]        dutyOut
);
  localparam int SUM_W    = INT_W + GAIN_W + 2;
  localparam int DUTY_MAX = (1 << DUTY_W) - 1;

  logic signed [INT_W-1:0] integ [PID_NUM_BANDS];
  logic signed [ERR_W-1:0] prevErr;
  logic signed [SUM_W-1:0] errX, prevX, selX, intRaw, intSat;
  logic signed [SUM_W-1:0] pTerm, dTerm, ffTerm, total;
  logic [DUTY_W-1:0]       dutyNext;

  always_comb begin
    errX   = SUM_W'(errIn);
    prevX  = SUM_W'(prevErr);
    selX   = SUM_W'(integ[ctl.bandIdx]);
    intRaw = selX + errX * SUM_W'(KI);
    if (intRaw > SUM_W'(INT_LIM))       intSat = SUM_W'(INT_LIM);
    else if (intRaw < -SUM_W'(INT_LIM)) intSat = -SUM_W'(INT_LIM);
    else                                intSat = intRaw;
    pTerm  = errX * SUM_W'(KP);
    dTerm  = (errX - prevX) * SUM_W'(KD);
    ffTerm = (SUM_W'(ffIn) * $signed(SUM_W'(ffGain))) >>> FF_SHIFT;
    total  = pTerm + intSat + dTerm + ffTerm;
    if (total < 0)                        dutyNext = '0;
    else if (total > SUM_W'(DUTY_MAX))    dutyNext = DUTY_W'(DUTY_MAX);
    else                                  dutyNext = total[DUTY_W-1:0];
  end

  for (genvar g = 0; g < PID_NUM_BANDS; g++) begin : g_band
    always_ff @(posedge clk) begin
      if (rst)                                integ[g] <= '0;
      else if (ctl.sample && ctl.bandHot[g])  integ[g] <= INT_W'(intSat);
    end

    // R3: an integrator not selected on a strobe keeps its value
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !(ctl.sample && ctl.bandHot[g]) |=> $stable(integ[g]));
    // R4: stored integrator never leaves its saturation window
    assert_int_limit_R4: assert property (@(posedge clk) disable iff (rst)
      (integ[g] <= INT_W'(INT_LIM)) && (integ[g] >= -INT_W'(INT_LIM)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevErr <= '0;
      dutyOut <= '0;
    end else if (ctl.sample) begin
      prevErr <= errIn;
      dutyOut <= dutyNext;
    end
  end

  // R9: without a strobe the command holds
  assert_duty_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !ctl.sample |=> $stable(dutyOut));
  // R10: reset clears output and derivative history on the next edge
  assert_clear_R10: assert property (@(posedge clk)
    rst |=> (dutyOut == '0) && (prevErr == '0));
endmodule

// File: rtl/pid_band_comp.sv
module pid_band_comp
  import pid_band_pkg::*;
#(
  parameter int ERR_W    = 10,
  parameter int LOAD_W   = 8,
  parameter int FF_W     = 8,
  parameter int GAIN_W   = 8,
  parameter int DUTY_W   = 13,
  parameter int INT_W    = 16,
  parameter int INT_LIM  = 16000,
  parameter int KP       = 8,
  parameter int KI       = 4,
  parameter int KD       = 2,
  parameter int FF_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleStb,
  input  logic [ERR_W-1:0]  errIn,
  input  logic [LOAD_W-1:0] loadCode,
  input  logic [FF_W-1:0]   ffIn,
  input  logic [GAIN_W-1:0] ffGain,
  output logic [DUTY_W-1:0] dutyOut
);
  pid_ctl_t ctl;

  pid_band_ctl #(.LOAD_W(LOAD_W)) i_ctl (
    .clk(clk), .rst(rst), .sampleStb(sampleStb), .loadCode(loadCode), .ctl(ctl)
  );

  pid_band_dp #(
    .ERR_W(ERR_W), .FF_W(FF_W), .GAIN_W(GAIN_W), .DUTY_W(DUTY_W),
    .INT_W(INT_W), .INT_LIM(INT_LIM), .KP(KP), .KI(KI), .KD(KD),
    .FF_SHIFT(FF_SHIFT)
  ) i_dp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .errIn($signed(errIn)), .ffIn($signed(ffIn)), .ffGain(ffGain),
    .dutyOut(dutyOut)
  );
endmodule

// File: tb/test_pid_band_comp.sv
module test_pid_band_comp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sampleStb = 1'b0;
  logic [9:0]  errIn = '0;
  logic [7:0]  loadCode = '0;
  logic [7:0]  ffIn = '0;
  logic [7:0]  ffGain = '0;
  logic [12:0] dutyOut;

  int checks = 0;
  int failures = 0;
  int mInt [8];
  int mPrev = 0;
  int mDuty = 0;

  always #5 clk = ~clk;

  pid_band_comp i_pid_band_comp (
    .clk(clk), .rst(rst), .sampleStb(sampleStb), .errIn(errIn),
    .loadCode(loadCode), .ffIn(ffIn), .ffGain(ffGain), .dutyOut(dutyOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int b = 0; b < 8; b++) mInt[b] = 0;
    mPrev = 0;
    mDuty = 0;
  endtask

  // Expected duty per R4..R8, updating the model state
  function automatic int modelStep(int e, int ld, int ff, int g);
    int band, iv, tot;
    band = ld >> 5;
    iv = mInt[band] + 4 * e;
    if (iv > 16000) iv = 16000;
    if (iv < -16000) iv = -16000;
    mInt[band] = iv;
    tot = 8 * e + iv + 2 * (e - mPrev) + ((ff * g) >>> 4);
    mPrev = e;
    if (tot < 0) tot = 0;
    if (tot > 8191) tot = 8191;
    mDuty = tot;
    return tot;
  endfunction

  task automatic strobe(input string req, input int e, input int ld,
                        input int ff, input int g);
    int exp;
    @(negedge clk);
    errIn = 10'(e); loadCode = 8'(ld); ffIn = 8'(ff); ffGain = 8'(g);
    sampleStb = 1'b1;
    exp = modelStep(e, ld, ff, g);
    @(negedge clk);
    sampleStb = 1'b0;
    check(req, int'(dutyOut), exp);
    // R9: junk inputs without a strobe must not move the output
    for (int k = 0; k < 3; k++) begin
      errIn = 10'($urandom); loadCode = 8'($urandom);
      ffIn = 8'($urandom); ffGain = 8'($urandom);
      @(negedge clk);
      if (k == 2) check("R9 hold between strobes", int'(dutyOut), mDuty);
    end
  endtask

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset duty", int'(dutyOut), 0);
    // R1: first strobe after reset shows zero history and integrators
    strobe("R1 R5 R6 first update", 10, 8'h00, 0, 0);          // 80+40+20
    strobe("R5 R6 proportional and derivative", -5, 8'h00, 0, 0);
    // R7: feedforward, negative sample floors on shift
    strobe("R7 feedforward positive", 0, 8'h20, 100, 200);
    strobe("R7 feedforward negative", 0, 8'h20, -3, 7);
    // R4 saturation on band 2, then unwind observably
    for (int i = 0; i < 10; i++) strobe("R4 R8 saturate high", 511, 8'h40, 0, 0);
    for (int i = 0; i < 3; i++) strobe("R4 unwind from limit", -511, 8'h40, 0, 0);
    // R8 low clamp on band 5
    for (int i = 0; i < 10; i++) strobe("R8 clamp low", -511, 8'hA0, 0, 0);
    // R2 R3: other bands untouched, band 2 resumes
    strobe("R2 band 7 fresh", 20, 8'hFF, 0, 0);
    strobe("R3 band 2 resumes", 20, 8'h5F, 0, 0);
    strobe("R3 band 5 resumes", 0, 8'hBF, 0, 0);
    strobe("R2 band 0 resumes", 0, 8'h1F, 0, 0);
    // Random mixture over all bands
    for (int i = 0; i < 400; i++)
      strobe("R2 R4 R5 R6 R7 R8 random",
             int'($urandom_range(0, 1022)) - 511, int'($urandom_range(0, 255)),
             int'($urandom_range(0, 255)) - 128, int'($urandom_range(0, 255)));
    // R10: reset mid-run clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    modelReset();
    check("R10 reset clears duty", int'(dutyOut), 0);
    for (int b = 0; b < 8; b++)
      strobe("R10 integrators cleared", 10, b << 5, 0, 0);
    finishRun();
  end
endmodule